// File: doc/BRIEF.md
# Byte-Serial Counter Channel Host Port

This block is the host-facing register port of one counter channel whose count is 24 bits wide. The host sees two byte-wide ports. A control write is a command byte, and its two target bits route it to one of four places. The first is an action group that moves the byte pointer, clears the core's flags and starts transfers. The other three are the counting-mode, input/output and index configuration registers, which are passed straight through to the counter core.

Multi-byte values cross a single data port. A shared byte pointer picks one byte of the preset register on writes, or one byte of the output latch on reads. The pointer moves forward after every data access. The counter core can only be given a new count in two steps: first fill the preset register, then command a preset-to-counter transfer. The block raises one-cycle strobes toward the core for that load, for the prescaler load and for flag clears. It also returns a status byte made from the core's error and direction flags.

Top module: `ctr_host_port`

## Requirements
- R1: A control write whose bits [6:5] equal 1 loads bits [4:0] into `mode_cfg`. A value of 2 loads bits [4:0] into `io_cfg`. A value of 3 loads bits [1:0] into `idx_cfg`. A value of 0 changes none of the three. Bit 7 of a control byte has no effect, and the configuration outputs keep their value when there is no control write.
- R2: In an action command (bits [6:5] = 0), bit 0 = 1 returns the byte pointer to byte 0.
- R3: The byte pointer is shared by data reads and data writes. It advances by one after each data access and wraps to 0 after byte 2.
- R4: A data write loads `wr_byte` into the preset byte selected by the pointer. Byte 0 is the least significant byte, so three writes from pointer 0 fill the preset LSB first. `preset_val` shows the result.
- R5: `rd_byte` shows the output-latch byte selected by the pointer, with byte 0 the least significant byte.
- R6: An action command with bits [4:3] = 2 copies `core_count`, as sampled at the command's clock edge, into the output latch.
- R7: An action command with bits [4:3] = 1 pulses `count_load` for exactly one cycle after the command edge. During that cycle `count_load_val` holds the preset value as it stood before the command edge, even when a data write happens on the same edge.
- R8: An action command with bits [4:3] = 3 pulses `psc_load` for one cycle and sets `psc_val` to the preset low byte as it stood before the command edge.
- R9: An action command with bits [2:1] = 2 pulses `clr_flags` for one cycle. A value of 3 pulses `clr_err` for one cycle. Values 0 and 1 pulse neither.
- R10: `status_byte` bit 4 is `core_err`, bit 5 is `core_up` (1 = counting up), and all other bits are 0.
- R11: All actions encoded in one command take effect on the same edge. Example: command 0x11 latches the count and resets the pointer, and the next three reads return the latched count LSB first.
- R12: After reset the pointer, preset, latch, prescaler value and configuration outputs are all 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe (advances pointer) |
| wr_byte | input | 8 | Write data for both ports |
| rd_byte | output | 8 | Output-latch byte at the pointer |
| status_byte | output | 8 | Status: bit 4 error, bit 5 up direction |
| core_count | input | 24 | Live count from the counter core |
| core_err | input | 1 | Noise error flag from the core |
| core_up | input | 1 | Direction flag from the core |
| preset_val | output | 24 | Preset register contents |
| count_load | output | 1 | Preset-to-counter strobe |
| count_load_val | output | 24 | Value to load into the counter |
| psc_load | output | 1 | Prescaler load strobe |
| psc_val | output | 8 | Prescaler value |
| clr_flags | output | 1 | Clear borrow/carry/compare/sign/index strobe |
| clr_err | output | 1 | Clear error flag strobe |
| mode_cfg | output | 5 | Counting-mode configuration |
| io_cfg | output | 5 | Input/output configuration |
| idx_cfg | output | 2 | Index configuration |

## Verification
The bench applies every one of the 256 control bytes from a known pointer position, preset and live count, then compares each strobe, the configuration outputs and the latch byte under the pointer against an arithmetic model. That sweep catches a target decode on the wrong bits, bit 7 being honoured, a clear strobe that also fires for codes 0 or 1, and a pointer reset that leaks into non-action targets. Other tests run the pointer past its wrap with reads and writes mixed. A design that wrapped at 3, or kept separate read and write pointers, would return the wrong latch byte. The bench also writes a data byte on the same edge as a preset-to-counter command. A design that forwarded the new preset would present the wrong load value.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    TGT_ACT  = 2'd0,
    TGT_MODE = 2'd1,
    TGT_IO   = 2'd2,
    TGT_IDX  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_PR2CNT = 2'd1,
    XF_CNT2OL = 2'd2,
    XF_PR2PSC = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    CL_NONE0 = 2'd0,
    CL_NONE1 = 2'd1,
    CL_FLAGS = 2'd2,
    CL_ERR   = 2'd3
  } clr_e;

  typedef struct packed {
    logic ptr_rst;
    logic ld_mode;
    logic ld_io;
    logic ld_idx;
    logic pr2cnt;
    logic cnt2ol;
    logic pr2psc;
    logic clr_flags;
    logic clr_err;
  } cmd_t;
endpackage

// File: rtl/cbi_cmd_decode.sv
module cbi_cmd_decode
  import cbi_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] cmd_byte,
  output cmd_t       cmd
);
  tgt_e  tgt;
  xfer_e xf;
  clr_e  cl;
  logic  act;

  always_comb begin
    tgt = tgt_e'(cmd_byte[6:5]);
    xf  = xfer_e'(cmd_byte[4:3]);
    cl  = clr_e'(cmd_byte[2:1]);
    act = wr_en && (tgt == TGT_ACT);
    cmd.ptr_rst   = act && cmd_byte[0];
    cmd.ld_mode   = wr_en && (tgt == TGT_MODE);
    cmd.ld_io     = wr_en && (tgt == TGT_IO);
    cmd.ld_idx    = wr_en && (tgt == TGT_IDX);
    cmd.pr2cnt    = act && (xf == XF_PR2CNT);
    cmd.cnt2ol    = act && (xf == XF_CNT2OL);
    cmd.pr2psc    = act && (xf == XF_PR2PSC);
    cmd.clr_flags = act && (cl == CL_FLAGS);
    cmd.clr_err   = act && (cl == CL_ERR);
  end
endmodule

// File: rtl/cbi_byte_ptr.sv
module cbi_byte_ptr #(
  parameter int NB = 3,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  logic [PW-1:0] ptr_d, ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)
      ptr_d = '0;
    else if (step)
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (clr || step)
      ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  // R2
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0));
  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ptr_q == LAST) |=> (ptr_q == '0));
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(ptr_q));
endmodule

// File: rtl/cbi_data_regs.sv
module cbi_data_regs
  import cbi_pkg::*;
#(
  parameter int CW = 24,
  localparam int NB = CW / 8,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_t          cmd,
  input  logic          data_wr,
  input  logic [PW-1:0] ptr,
  input  logic [7:0]    wr_byte,
  input  logic [CW-1:0] core_count,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] preset_val,
  output logic          count_load,
  output logic [CW-1:0] count_load_val,
  output logic          psc_load,
  output logic [7:0]    psc_val,
  output logic          clr_flags,
  output logic          clr_err
);
  logic [NB-1:0][7:0] preset_q, preset_d;
  logic [NB-1:0][7:0] latch_q, latch_d;
  logic [CW-1:0]      ldval_q;
  logic [7:0]         psc_q;
  logic               ld_q, psl_q, clf_q, cle_q;

  always_comb begin
    preset_d = preset_q;
    if (data_wr)
      preset_d[ptr] = wr_byte;
    latch_d = core_count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      preset_q <= '0;
    else if (data_wr)
      preset_q <= preset_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      latch_q <= '0;
    else if (cmd.cnt2ol)
      latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ldval_q <= '0;
    else if (cmd.pr2cnt)
      ldval_q <= preset_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      psc_q <= '0;
    else if (cmd.pr2psc)
      psc_q <= preset_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b0;
      psl_q <= 1'b0;
      clf_q <= 1'b0;
      cle_q <= 1'b0;
    end else begin
      ld_q  <= cmd.pr2cnt;
      psl_q <= cmd.pr2psc;
      clf_q <= cmd.clr_flags;
      cle_q <= cmd.clr_err;
    end
  end

  assign rd_byte        = latch_q[ptr];
  assign preset_val     = preset_q;
  assign count_load     = ld_q;
  assign count_load_val = ldval_q;
  assign psc_load       = psl_q;
  assign psc_val        = psc_q;
  assign clr_flags      = clf_q;
  assign clr_err        = cle_q;

  // R7
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.pr2cnt |=> (count_load && count_load_val == $past(preset_q)));
  // R6
  latch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.cnt2ol |=> (latch_q == $past(core_count)));
  // R8
  psc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.pr2psc |=> (psc_load && psc_val == $past(preset_q[0])));
  // R9
  clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_flags && clr_err));
  // R4
  preset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(preset_q));
endmodule

// File: rtl/ctr_host_port.sv
module ctr_host_port
  import cbi_pkg::*;
#(
  parameter int CW = 24,
  localparam int NB = CW / 8,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [7:0]    wr_byte,
  output logic [7:0]    rd_byte,
  output logic [7:0]    status_byte,
  input  logic [CW-1:0] core_count,
  input  logic          core_err,
  input  logic          core_up,
  output logic [CW-1:0] preset_val,
  output logic          count_load,
  output logic [CW-1:0] count_load_val,
  output logic          psc_load,
  output logic [7:0]    psc_val,
  output logic          clr_flags,
  output logic          clr_err,
  output logic [4:0]    mode_cfg,
  output logic [4:0]    io_cfg,
  output logic [1:0]    idx_cfg
);
  logic [1:0]    rst_sync;
  logic          rst_ni;
  cmd_t          cmd;
  logic [PW-1:0] ptr;
  logic [4:0]    mode_q, mode_d, io_q, io_d;
  logic [1:0]    idx_q, idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync <= 2'b00;
    else
      rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cbi_cmd_decode i_dec (
    .wr_en    (ctrl_wr),
    .cmd_byte (wr_byte),
    .cmd      (cmd)
  );

  cbi_byte_ptr #(.NB(NB)) i_ptr (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (cmd.ptr_rst),
    .step  (data_wr || data_rd),
    .ptr   (ptr)
  );

  cbi_data_regs #(.CW(CW)) i_regs (
    .clk            (clk),
    .rst_n          (rst_ni),
    .cmd            (cmd),
    .data_wr        (data_wr),
    .ptr            (ptr),
    .wr_byte        (wr_byte),
    .core_count     (core_count),
    .rd_byte        (rd_byte),
    .preset_val     (preset_val),
    .count_load     (count_load),
    .count_load_val (count_load_val),
    .psc_load       (psc_load),
    .psc_val        (psc_val),
    .clr_flags      (clr_flags),
    .clr_err        (clr_err)
  );

  always_comb begin
    mode_d = cmd.ld_mode ? wr_byte[4:0] : mode_q;
    io_d   = cmd.ld_io   ? wr_byte[4:0] : io_q;
    idx_d  = cmd.ld_idx  ? wr_byte[1:0] : idx_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      io_q   <= '0;
      idx_q  <= '0;
    end else begin
      if (cmd.ld_mode) mode_q <= mode_d;
      if (cmd.ld_io)   io_q   <= io_d;
      if (cmd.ld_idx)  idx_q  <= idx_d;
    end
  end

  assign mode_cfg    = mode_q;
  assign io_cfg      = io_q;
  assign idx_cfg     = idx_q;
  assign status_byte = {2'b00, core_up, core_err, 4'b0000};

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctrl_wr |=> ($stable(mode_cfg) && $stable(io_cfg) && $stable(idx_cfg)));
  // R1
  act_cfg_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && wr_byte[6:5] == 2'd0) |=> ($stable(mode_cfg) && $stable(io_cfg) && $stable(idx_cfg)));
  // R9
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (count_load || psc_load || clr_flags || clr_err) |-> $past(ctrl_wr));
endmodule

// File: tb/test_ctr_host_port.sv
module test_ctr_host_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [7:0]  rd_byte, status_byte, psc_val;
  logic [23:0] core_count = '0;
  logic        core_err = 1'b0, core_up = 1'b0;
  logic [23:0] preset_val, count_load_val;
  logic        count_load, psc_load, clr_flags, clr_err;
  logic [4:0]  mode_cfg, io_cfg;
  logic [1:0]  idx_cfg;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [23:0] m_preset, m_latch;
  logic [7:0]  m_psc;
  logic [4:0]  m_mode, m_io;
  logic [1:0]  m_idx;
  int          m_ptr;

  always #5 clk = ~clk;

  ctr_host_port i_ctr_host_port (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wr_byte(wr_byte), .rd_byte(rd_byte), .status_byte(status_byte),
    .core_count(core_count), .core_err(core_err), .core_up(core_up),
    .preset_val(preset_val), .count_load(count_load), .count_load_val(count_load_val),
    .psc_load(psc_load), .psc_val(psc_val), .clr_flags(clr_flags), .clr_err(clr_err),
    .mode_cfg(mode_cfg), .io_cfg(io_cfg), .idx_cfg(idx_cfg)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_preset = '0; m_latch = '0; m_psc = '0;
    m_mode = '0; m_io = '0; m_idx = '0; m_ptr = 0;
  endtask

  // drive a control byte; returns at the negedge after the capturing edge
  task automatic ctrl(input logic [7:0] b);
    @(negedge clk); ctrl_wr = 1'b1; wr_byte = b;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic model_cmd(input logic [7:0] b);
    case (b[6:5])
      2'd0: begin
        if (b[4:3] == 2'd2) m_latch = core_count;
        if (b[4:3] == 2'd3) m_psc = m_preset[7:0];
        if (b[0]) m_ptr = 0;
      end
      2'd1: m_mode = b[4:0];
      2'd2: m_io = b[4:0];
      default: m_idx = b[1:0];
    endcase
  endtask

  task automatic dwrite(input logic [7:0] b);
    @(negedge clk); data_wr = 1'b1; wr_byte = b;
    @(negedge clk); data_wr = 1'b0;
    m_preset[8*m_ptr +: 8] = b;
    m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
  endtask

  task automatic dread(output logic [7:0] b);
    @(negedge clk); data_rd = 1'b1; b = rd_byte;
    @(negedge clk); data_rd = 1'b0;
    m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
  endtask

  task automatic check_all(input string req);
    chk(req, "mode_cfg", 32'(mode_cfg), 32'(m_mode));
    chk(req, "io_cfg", 32'(io_cfg), 32'(m_io));
    chk(req, "idx_cfg", 32'(idx_cfg), 32'(m_idx));
    chk(req, "psc_val", 32'(psc_val), 32'(m_psc));
    chk(req, "preset_val", 32'(preset_val), 32'(m_preset));
    chk(req, "rd_byte", 32'(rd_byte), 32'(m_latch[8*m_ptr +: 8]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    check_all("R12");
    chk("R12", "strobes", {28'd0, count_load, psc_load, clr_flags, clr_err}, 32'd0);

    // R4 / R7: fill preset LSB first, then load counter
    ctrl(8'h01); model_cmd(8'h01);
    dwrite(8'h1E); dwrite(8'hA5); dwrite(8'hC3);
    chk("R4", "preset_val", 32'(preset_val), 32'h00C3A51E);
    ctrl(8'h08);
    chk("R7", "count_load", 32'(count_load), 32'd1);
    chk("R7", "count_load_val", 32'(count_load_val), 32'h00C3A51E);
    @(negedge clk);
    chk("R7", "count_load one cycle", 32'(count_load), 32'd0);

    // R11 / R5: latch + pointer reset in one command, read LSB first
    core_count = 24'h7B2D90;
    dread(rb);                       // move pointer off 0
    ctrl(8'h11); model_cmd(8'h11);
    dread(rb); chk("R11", "byte0", 32'(rb), 32'h90);
    dread(rb); chk("R5", "byte1", 32'(rb), 32'h2D);
    dread(rb); chk("R5", "byte2", 32'(rb), 32'h7B);
    // R3 wrap and shared pointer: write byte 0 then read byte 1
    dwrite(8'h44);
    chk("R3", "preset after wrap", 32'(preset_val), 32'h00C3A544);
    dread(rb); chk("R3", "shared pointer read", 32'(rb), 32'h2D);

    // R7 / R11: data write on the same edge as preset-to-counter command
    ctrl(8'h01); model_cmd(8'h01);
    @(negedge clk); ctrl_wr = 1'b1; data_wr = 1'b1; wr_byte = 8'h08;
    @(negedge clk); ctrl_wr = 1'b0; data_wr = 1'b0;
    chk("R7", "load uses old preset", 32'(count_load_val), 32'h00C3A544);
    m_preset[7:0] = 8'h08; m_ptr = 1;
    chk("R4", "same-edge write landed", 32'(preset_val), 32'(m_preset));

    // R10 status sweep
    for (int s = 0; s < 4; s++) begin
      core_err = s[0]; core_up = s[1];
      #1;
      chk("R10", "status_byte", 32'(status_byte), 32'({s[1], s[0], 4'b0000}));
    end

    // R1 R2 R6 R8 R9: sweep every control byte from a known state
    for (int c = 0; c < 256; c++) begin
      logic [7:0] b;
      b = 8'(c);
      core_count = 24'(c * 32'h00010101 ^ 32'h005A3C1);
      ctrl(8'h01); model_cmd(8'h01);
      dread(rb);                     // pointer now 1
      ctrl(b);
      chk("R7", "count_load", 32'(count_load), 32'(b[6:5] == 2'd0 && b[4:3] == 2'd1));
      if (b[6:5] == 2'd0 && b[4:3] == 2'd1)
        chk("R7", "count_load_val", 32'(count_load_val), 32'(m_preset));
      chk("R8", "psc_load", 32'(psc_load), 32'(b[6:5] == 2'd0 && b[4:3] == 2'd3));
      chk("R9", "clr_flags", 32'(clr_flags), 32'(b[6:5] == 2'd0 && b[2:1] == 2'd2));
      chk("R9", "clr_err", 32'(clr_err), 32'(b[6:5] == 2'd0 && b[2:1] == 2'd3));
      model_cmd(b);
      check_all("R1");
      chk("R2", "pointer via rd_byte", 32'(rd_byte), 32'(m_latch[8*m_ptr +: 8]));
      chk("R6", "latch byte", 32'(rd_byte), 32'(m_latch[8*m_ptr +: 8]));
      @(negedge clk);
      chk("R9", "strobes one cycle", {28'd0, count_load, psc_load, clr_flags, clr_err}, 32'd0);
    end

    // R12 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    check_all("R12");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule